// File: doc/BRIEF.md
# Reversible-Gate Ripple Carry Adder

This block adds two N-bit operands and a carry-in. Each bit position is one 4-input, 4-output reversible gate. Every input pattern of a gate maps to its own distinct output pattern. A stage gets its operand bits, the carry from the stage below and a constant-zero fourth input. It returns its sum bit, its carry to the next stage and two further lines that no other logic consumes. Those two lines are not discarded. They leave the block on a garbage bus, so that together with sum and carry-out the full input of every gate can still be reconstructed.

The carry chain is a plain series connection: stage 0 takes the external carry-in, and stage i takes the carry produced by stage i-1. A parameter places an optional register on all outputs. The outputs are either combinational or appear one clock after the operands. A separate inverse-gate module maps a gate's four outputs back to its four inputs. Benches use it to demonstrate reversibility.

Top module: `rev_ripple_adder`

## Requirements
- R1: The gate maps inputs (a, b, c, d) to p = a, q = a xor b, r = a xor b xor c, s = ((a xor b) and c) xor (a and b) xor d.
- R2: With d held at 0, gate output r equals the sum bit of a + b + c and s equals its carry bit.
- R3: The gate is bijective: the 16 input patterns give 16 distinct outputs, and the inverse module returns the original (a, b, c, d) from (p, q, r, s) for each of them.
- R4: {cout, sum} equals a + b + cin, taken as an (N+1)-bit unsigned result.
- R5: Carry ripples through every stage in series from cin: with a all ones, b zero and cin one, sum is zero and cout is one.
- R6: garbage bit 2i carries a[i], and garbage bit 2i+1 carries a[i] xor b[i], for every stage i.
- R7: With REG_OUT = 1, sum, cout and garbage reflect the operands sampled at the previous rising clock edge and hold steady between edges. With REG_OUT = 0 they follow the operands within the same cycle.
- R8: With REG_OUT = 1, a rising edge with rst_n low clears sum, cout and garbage to zero whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into stage 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of the top stage |
| garbage | output | 2N | Unused gate outputs, two per stage |

## Verification
In the registered variant, a longest carry ripple and the output register capture fall in the same cycle. The bench applies all-ones plus carry-in right after other operands. Just before the next edge it confirms that the previous result still holds, and after the edge it confirms that the fully rippled result appears. Reset and data can also coincide: reset is asserted on the same edge that captures a full-carry pattern, and the scoreboard then expects an all-zero output in place of the sum. Every operand pair at 4 bits, plus random 16-bit pairs through an unregistered instance, is compared with an arithmetic model.

// File: rtl/rev_adder_pkg.sv
// Shared types for the reversible ripple adder.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package rev_adder_pkg;

    // Input side of one 4x4 reversible gate.
    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } gate_in_t;

    // Output side of one 4x4 reversible gate.
    typedef struct packed {
        logic p;
        logic q;
        logic r;
        logic s;
    } gate_out_t;

    // Garbage lines kept per stage (p and q).
    localparam int GARB_PER_STAGE = 2;

endpackage

// File: rtl/rev_fa_gate.sv
// One 4x4 reversible gate.
// p = a, q = a^b, r = a^b^c, s = ((a^b)&c)^(a&b)^d.
// With d = 0 it is a full adder: r is the sum, s is the carry.
// Purely combinational; bijective over its 16 input patterns.
module rev_fa_gate
    import rev_adder_pkg::*;
(
    input  gate_in_t  x,
    output gate_out_t y
);

    logic ab_x;

    // Forward map of the gate.
    always_comb begin
        ab_x = x.a ^ x.b;
        y.p  = x.a;
        y.q  = ab_x;
        y.r  = ab_x ^ x.c;
        y.s  = (ab_x & x.c) ^ (x.a & x.b) ^ x.d;
    end

endmodule

// File: rtl/rev_fa_gate_inv.sv
// Inverse of rev_fa_gate: recovers (a, b, c, d) from (p, q, r, s).
// Assumes its input was produced by rev_fa_gate; purely combinational.
module rev_fa_gate_inv
    import rev_adder_pkg::*;
(
    input  gate_out_t y,
    output gate_in_t  x
);

    // Undo the forward map one output at a time.
    always_comb begin
        x.a = y.p;
        x.b = y.q ^ y.p;
        x.c = y.r ^ y.q;
        x.d = y.s ^ (y.q & (y.r ^ y.q)) ^ (y.p & (y.q ^ y.p));
    end

endmodule

// File: rtl/rev_ripple_chain.sv
// N stages of rev_fa_gate in series, each with d tied to zero.
// Stage i carry feeds stage i+1 input c; stage 0 takes cin.
// Exposes p and q of every stage on the garbage bus.
module rev_ripple_chain
    import rev_adder_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]                a,
    input  logic [N-1:0]                b,
    input  logic                        cin,
    output logic [N-1:0]                sum,
    output logic                        cout,
    output logic [GARB_PER_STAGE*N-1:0] garbage
);

    logic [N:0] carry;

    assign carry[0] = cin;
    assign cout     = carry[N];

    for (genvar i = 0; i < N; i++) begin : g_stage
        gate_in_t  gi;
        gate_out_t go;

        // Assemble this stage's gate inputs.
        always_comb begin
            gi.a = a[i];
            gi.b = b[i];
            gi.c = carry[i];
            gi.d = 1'b0;
        end

        rev_fa_gate u_gate (
            .x (gi),
            .y (go)
        );

        assign sum[i]                    = go.r;
        assign carry[i+1]                = go.s;
        assign garbage[GARB_PER_STAGE*i]   = go.p;
        assign garbage[GARB_PER_STAGE*i+1] = go.q;
    end

endmodule

// File: rtl/rev_out_stage.sv
// Optional output register. REG_OUT = 1 selects the flopped copy,
// REG_OUT = 0 passes d straight through. Synchronous active-low reset.
module rev_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_reg;

    // Capture d each cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_reg <= '0;
        else        q_reg <= d;
    end

    if (REG_OUT) begin : g_reg
        assign q = q_reg;
    end else begin : g_comb
        assign q = d;
    end

endmodule

// File: rtl/rev_ripple_adder.sv
// Top: N-bit ripple adder of reversible gates with a garbage bus and
// an optional output register. Assumes REG_OUT is 0 or 1.
module rev_ripple_adder
    import rev_adder_pkg::*;
#(
    parameter int N       = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0]                a,
    input  logic [N-1:0]                b,
    input  logic                        cin,
    output logic [N-1:0]                sum,
    output logic                        cout,
    output logic [GARB_PER_STAGE*N-1:0] garbage
);

    localparam int GW    = GARB_PER_STAGE * N;
    localparam int OUT_W = N + 1 + GW;

    logic [N-1:0]     sum_c;
    logic             cout_c;
    logic [GW-1:0]    garb_c;
    logic [OUT_W-1:0] pack_d;
    logic [OUT_W-1:0] pack_q;

    rev_ripple_chain #(.N(N)) u_chain (
        .a       (a),
        .b       (b),
        .cin     (cin),
        .sum     (sum_c),
        .cout    (cout_c),
        .garbage (garb_c)
    );

    assign pack_d = {cout_c, garb_c, sum_c};

    rev_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pack_d),
        .q     (pack_q)
    );

    assign sum     = pack_q[N-1:0];
    assign garbage = pack_q[N +: GW];
    assign cout    = pack_q[OUT_W-1];

endmodule

// File: rtl/rev_ripple_adder_checker.sv
// Assertions for rev_ripple_adder, attached with bind below.
// Compares the ports with an arithmetic model of the requirements.
module rev_ripple_adder_checker #(
    parameter int N       = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic           cin,
    input logic [N-1:0]   sum,
    input logic           cout,
    input logic [2*N-1:0] garbage
);

    logic [N:0]     exp_total;
    logic [2*N-1:0] exp_garb;
    logic           full_carry;
    logic           seen_q;
    logic           rst_prev_q = 1'b0;

    // Model of the arithmetic result and the garbage lines.
    always_comb begin
        exp_total  = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
        full_carry = (a == {N{1'b1}}) && (b == '0) && cin;
        for (int i = 0; i < N; i++) begin
            exp_garb[2*i]   = a[i];
            exp_garb[2*i+1] = a[i] ^ b[i];
        end
    end

    // Marks that the previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // Remembers that reset was sampled low at the previous edge.
    always_ff @(posedge clk) rst_prev_q <= !rst_n;

    if (REG_OUT) begin : g_reg_chk
        a_r4_sum_registered: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q |-> ({cout, sum} == $past(exp_total)));
        a_r6_garbage_registered: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q |-> (garbage == $past(exp_garb)));
        a_r5_full_ripple_registered: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && $past(full_carry)) |-> (sum == '0 && cout));
        a_r8_reset_clears: assert property (@(posedge clk)
            rst_prev_q |-> (sum == '0 && !cout && garbage == '0));
    end else begin : g_comb_chk
        a_r4_sum_comb: assert property (@(posedge clk) disable iff (!rst_n)
            {cout, sum} == exp_total);
        a_r6_garbage_comb: assert property (@(posedge clk) disable iff (!rst_n)
            garbage == exp_garb);
        a_r5_full_ripple_comb: assert property (@(posedge clk) disable iff (!rst_n)
            full_carry |-> (sum == '0 && cout));
        a_r7_comb_follow: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(a) && $stable(b) && $stable(cin)) |-> $stable({cout, sum, garbage}));
    end

endmodule

bind rev_ripple_adder rev_ripple_adder_checker #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .garbage (garbage)
);

// File: tb/rev_ripple_adder_bench.sv
// Scoreboard bench: a driver pushes expected results, a monitor pops and
// compares them one cycle later against the registered 4-bit instance.
module rev_ripple_adder_bench;
    import rev_adder_pkg::*;

    localparam int NW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] a = '0, b = '0;
    logic cin = 1'b0;
    logic [3:0] sum;
    logic cout;
    logic [7:0] garbage;
    logic [NW-1:0] wa = '0, wb = '0;
    logic wcin = 1'b0;
    logic [NW-1:0] wsum;
    logic wcout;
    logic [2*NW-1:0] wgarb;
    gate_in_t gx, gback;
    gate_out_t gy;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [12:0] exp_q[$];
    string tag_q[$];
    logic [12:0] last_exp = '0;

    always #2 clk = ~clk;

    rev_ripple_adder u_rev_ripple_adder (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout), .garbage(garbage));

    rev_ripple_adder #(.N(NW), .REG_OUT(1'b0)) u_rev_ripple_adder_wide (
        .clk(clk), .rst_n(rst_n), .a(wa), .b(wb), .cin(wcin),
        .sum(wsum), .cout(wcout), .garbage(wgarb));

    rev_fa_gate     u_gate (.x(gx), .y(gy));
    rev_fa_gate_inv u_inv  (.y(gy), .x(gback));

    // Compare one value and record the outcome.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected packing {cout, garbage, sum} for the 4-bit instance (R4, R6).
    function automatic logic [12:0] model4(input logic [3:0] x, input logic [3:0] y, input logic c);
        logic [4:0] t;
        logic [7:0] g;
        t = {1'b0, x} + {1'b0, y} + {4'b0, c};
        for (int i = 0; i < 4; i++) begin
            g[2*i]   = x[i];
            g[2*i+1] = x[i] ^ y[i];
        end
        return {t[4], g, t[3:0]};
    endfunction

    // Driver: apply operands at a falling edge and push the expected result.
    task automatic drive(input logic [3:0] x, input logic [3:0] y, input logic c, input string req);
        @(negedge clk);
        a = x; b = y; cin = c;
        last_exp = model4(x, y, c);
        exp_q.push_back(last_exp);
        tag_q.push_back(req);
    endtask

    // Monitor: after each rising edge, pop and compare the oldest item.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [12:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {51'b0, cout, garbage, sum}, {51'b0, e});
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R8: reset wins over nonzero operands.
        a = 4'hF; b = 4'h1; cin = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reset state", {51'b0, cout, garbage, sum}, 64'd0);

        // R1, R2, R3: exhaustive gate and inverse checks.
        begin
            bit seen[16];
            int distinct;
            distinct = 0;
            for (int v = 0; v < 16; v++) seen[v] = 1'b0;
            for (int v = 0; v < 16; v++) begin
                logic ea, eb, ec, ed;
                logic [1:0] fa;
                {ea, eb, ec, ed} = v[3:0];
                gx = '{a: ea, b: eb, c: ec, d: ed};
                #1;
                check("R1 gate map", {60'b0, gy},
                      {60'b0, ea, ea ^ eb, ea ^ eb ^ ec, ((ea ^ eb) & ec) ^ (ea & eb) ^ ed});
                check("R3 inverse", {60'b0, gback}, {60'b0, v[3:0]});
                if (!seen[gy]) distinct++;
                seen[gy] = 1'b1;
                if (!ed) begin
                    fa = {1'b0, ea} + {1'b0, eb} + {1'b0, ec};
                    check("R2 full adder", {62'b0, gy.s, gy.r}, {62'b0, fa});
                end
            end
            check("R3 distinct outputs", 64'(distinct), 64'd16);
        end

        @(negedge clk);
        rst_n = 1'b1;

        // R4, R6: every 4-bit operand pair with both carry-in values.
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int c = 0; c < 2; c++)
                    drive(x[3:0], y[3:0], c[0], "R4 R6 exhaustive");

        // R7: a full ripple follows; the old result holds until the edge.
        drive(4'h3, 4'h4, 1'b0, "R7 before ripple");
        begin
            logic [12:0] held;
            held = last_exp;
            drive(4'hF, 4'h0, 1'b1, "R5 full ripple");
            #1;
            check("R7 hold before edge", {51'b0, cout, garbage, sum}, {51'b0, held});
        end
        drive(4'hA, 4'h5, 1'b1, "R5 ripple via propagate");

        // R8: reset on the same edge as a full-carry pattern.
        @(negedge clk);
        a = 4'hF; b = 4'h0; cin = 1'b1; rst_n = 1'b0;
        exp_q.push_back(13'd0);
        tag_q.push_back("R8 reset with data");
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'h7, 4'h9, 1'b0, "R4 after reset");
        repeat (2) @(negedge clk);

        // R7 combinational variant, R4 R5 R6 at 16 bits.
        for (int k = 0; k < 300; k++) begin
            logic [NW:0] t;
            logic [2*NW-1:0] g;
            @(negedge clk);
            if (k == 0) begin
                wa = '1; wb = '0; wcin = 1'b1;
            end else begin
                wa = NW'($urandom); wb = NW'($urandom); wcin = 1'($urandom);
            end
            #1;
            t = {1'b0, wa} + {1'b0, wb} + {{NW{1'b0}}, wcin};
            for (int i = 0; i < NW; i++) begin
                g[2*i]   = wa[i];
                g[2*i+1] = wa[i] ^ wb[i];
            end
            check(k == 0 ? "R5 wide full ripple" : "R4 R7 wide sum",
                  {47'b0, wcout, wsum}, {47'b0, t});
            check("R6 wide garbage", {32'b0, wgarb}, {32'b0, g});
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule